// File: doc/BRIEF.md
# In-Order Completion Queue

This block keeps a sixteen-slot circular record of instructions in the order they were dispatched. Each cycle the dispatch stage can claim up to three slots at the tail. The block hands back one 4-bit tag for each claimed slot. Execution units later report, by tag, that an instruction has finished and whether it raised an exception. The block then releases instructions from the head strictly in order, at most three per cycle. An instruction is released only when it has finished, carries no exception, and every older instruction has already left.

Branches are marked when their slots are claimed, and they stay unresolved until the branch-resolve port reports on them. When a branch resolves as mispredicted, every younger slot is discarded and the tail moves to the slot just after the branch. The branch itself stays and leaves normally. An exception at the oldest unreleased instruction stops the release in front of that instruction. It raises a request that carries the instruction's tag, and the whole queue is emptied on the next edge. Writing results into the register files and vectoring the exception are left to other blocks.

Top module: `inorder_cq`

## Requirements
- R1: After reset the queue is empty: `free_cnt` is 16, `ret_cnt` is 0, `exc_req` is 0 and the first offered tag is 0. At most 16 instructions can be held, and `free_cnt` reads 0 when all 16 slots are occupied.
- R2: `alloc_cnt` (0 to 3) claims that many slots at the tail. Field k of `alloc_tag` (bits 4k+3 down to 4k) gives the tag of the k-th claimed slot, which is the tail slot number plus k, modulo 16. In the cycle after a claim, `free_cnt` equals the old value, minus the slots claimed, plus the slots retired. A claimed slot starts out unfinished.
- R3: If `alloc_cnt` is larger than `free_cnt`, the whole request is refused. No slot is claimed, and the offered tags do not move.
- R4: A finish report in cycle t (`fin_vld[p]` set, with the tag in field p of `fin_tag`) is first reflected in `ret_cnt` in cycle t+1. It is never reflected in the cycle the report arrives.
- R5: Retirement is in program order and stops at the first slot that cannot leave. `ret_cnt` (0 to 3) gives how many leave at the next edge, and field k of `ret_tag` gives the tag of the k-th one, counted from the head.
- R6: A slot claimed with its `alloc_br` bit set cannot retire until it has both finished and been resolved through the branch-resolve port.
- R7: A resolve with `br_mis` set, naming an occupied slot, discards every younger slot and every claim made in the same cycle. The next offered tag becomes the branch tag plus one, and the branch retires once it has finished.
- R8: When the first slot that cannot retire has finished with its exception flag set, `exc_req` is 1 and `exc_tag` carries that slot's tag. Older slots in the same window still retire in that cycle. In the next cycle the queue is empty (`free_cnt` 16), and any claim or mispredict made in the exception cycle has no effect.
- R9: Tags wrap from 15 back to 0. A full queue of 16 drains completely, with all 16 tags retired in ascending wrapped order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_cnt | input | 2 | Number of slots to claim this cycle (0 to 3) |
| alloc_br | input | 3 | Bit k marks the k-th claimed slot as a branch |
| alloc_tag | output | 12 | Tag of the k-th slot on offer, 4 bits per field |
| free_cnt | output | 5 | Number of unoccupied slots |
| fin_vld | input | 2 | Finish report valid, one bit per report port |
| fin_tag | input | 8 | Tag named by each finish report, 4 bits per port |
| fin_exc | input | 2 | Exception flag of each finish report |
| br_vld | input | 1 | Branch resolve valid |
| br_tag | input | 4 | Tag of the resolved branch |
| br_mis | input | 1 | Resolved branch was mispredicted |
| ret_cnt | output | 2 | Number of instructions retiring at the next edge |
| ret_tag | output | 12 | Tag of the k-th retiring instruction, 4 bits per field |
| exc_req | output | 1 | Oldest blocked instruction carries an exception |
| exc_tag | output | 4 | Tag of that instruction |

## Verification
A wrong head or tail pointer shows at once in `free_cnt` and in the offered tags. It shows within one cycle in `ret_tag`, because tags then leave out of order or are skipped during a drain. A finished or resolved flag that is stale, or that was never set, shows in the cycle after it matters: `ret_cnt` is either too large, or it stays at zero while the head should be leaving. A slot that a flush failed to clear keeps `free_cnt` below 16 in the cycle after a mispredict or an exception.

// File: rtl/cq_pkg.sv
// Shared types of the completion queue.
// Assumes: nothing beyond the standard types.
package cq_pkg;

    // Per-slot status flags.
    typedef struct packed {
        logic fin;      // execution finished
        logic exc;      // exception reported with the finish
        logic is_br;    // slot holds a branch
        logic br_done;  // branch has been resolved
    } cq_ent_t;

endpackage

// File: rtl/cq_ptrs.sv
// Head/tail pointer pair with a wrap bit, occupancy and free count.
// Assumes: DEPTH is a power of two; ret_cnt never exceeds occupancy.
module cq_ptrs #(
    parameter int DEPTH   = 16,
    parameter int ALLOC_N = 3,
    parameter int RET_N   = 3,
    localparam int TAG_W  = $clog2(DEPTH),
    localparam int PTR_W  = TAG_W + 1,
    localparam int AW     = $clog2(ALLOC_N + 1),
    localparam int RW     = $clog2(RET_N + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [RW-1:0]    ret_cnt,
    input  logic [AW-1:0]    alloc_req,
    input  logic             flush_all,
    input  logic             br_flush,
    input  logic [TAG_W-1:0] br_off,
    output logic [TAG_W-1:0] head_idx,
    output logic [TAG_W-1:0] tail_idx,
    output logic [PTR_W-1:0] occ,
    output logic [PTR_W-1:0] free_cnt,
    output logic [AW-1:0]    alloc_take
);

    logic [PTR_W-1:0] head_q, tail_q, head_nx;

    // Occupancy and free space from the pointer distance.
    always_comb begin
        occ      = tail_q - head_q;
        free_cnt = PTR_W'(DEPTH) - occ;
        head_nx  = head_q + PTR_W'(ret_cnt);
    end

    // Grant the whole claim or nothing; flushes cancel claims.
    always_comb begin
        if (!flush_all && !br_flush && (PTR_W'(alloc_req) <= free_cnt))
            alloc_take = alloc_req;
        else
            alloc_take = '0;
    end

    assign head_idx = head_q[TAG_W-1:0];
    assign tail_idx = tail_q[TAG_W-1:0];

    // Pointer update: retire moves head; flush or claim moves tail.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
        end else begin
            head_q <= head_nx;
            if (flush_all)
                tail_q <= head_nx;
            else if (br_flush)
                tail_q <= head_q + PTR_W'(br_off) + PTR_W'(1);
            else
                tail_q <= tail_q + PTR_W'(alloc_take);
        end
    end

    // R1
    occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= PTR_W'(DEPTH));

    // R3
    refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (PTR_W'(alloc_req) > free_cnt && !flush_all && !br_flush)
        |=> free_cnt == $past(free_cnt) + PTR_W'($past(ret_cnt)));

    // R8
    exc_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all |=> occ == '0);

endmodule

// File: rtl/cq_ent_array.sv
// Per-slot status registers: cleared on claim, set by finish and resolve.
// Assumes: a claim and a finish never name the same slot in one cycle
// unless the finish is stale; the claim wins.
module cq_ent_array
    import cq_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int FIN_N  = 2,
    localparam int TAG_W = $clog2(DEPTH)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [DEPTH-1:0]       wr_en,
    input  logic [DEPTH-1:0]       wr_br,
    input  logic [FIN_N-1:0]       fin_vld,
    input  logic [FIN_N*TAG_W-1:0] fin_tag,
    input  logic [FIN_N-1:0]       fin_exc,
    input  logic                   br_live,
    input  logic [TAG_W-1:0]       br_tag,
    output cq_ent_t [DEPTH-1:0]    ent
);

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        cq_ent_t e_q;
        logic    fin_hit, exc_hit, br_hit;

        // Merge the finish ports that name this slot.
        always_comb begin
            fin_hit = 1'b0;
            exc_hit = 1'b0;
            for (int p = 0; p < FIN_N; p++) begin
                if (fin_vld[p] && fin_tag[p*TAG_W +: TAG_W] == TAG_W'(i)) begin
                    fin_hit = 1'b1;
                    exc_hit = exc_hit | fin_exc[p];
                end
            end
            br_hit = br_live && (br_tag == TAG_W'(i));
        end

        // Slot flags: claim clears, reports set.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                e_q <= '0;
            end else if (wr_en[i]) begin
                e_q.fin     <= 1'b0;
                e_q.exc     <= 1'b0;
                e_q.is_br   <= wr_br[i];
                e_q.br_done <= 1'b0;
            end else begin
                if (fin_hit) begin
                    e_q.fin <= 1'b1;
                    e_q.exc <= e_q.exc | exc_hit;
                end
                if (br_hit)
                    e_q.br_done <= 1'b1;
            end
        end

        assign ent[i] = e_q;

        // R2
        alloc_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en[i] |=> !ent[i].fin);
    end

endmodule

// File: rtl/cq_retire_sel.sv
// Scans the oldest RET_N slots and picks how many leave this cycle.
// Assumes: ent is registered state; outputs depend on no input port.
module cq_retire_sel
    import cq_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int RET_N  = 3,
    localparam int TAG_W = $clog2(DEPTH),
    localparam int PTR_W = TAG_W + 1,
    localparam int RW    = $clog2(RET_N + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  cq_ent_t [DEPTH-1:0]    ent,
    input  logic [TAG_W-1:0]       head_idx,
    input  logic [PTR_W-1:0]       occ,
    output logic [RW-1:0]          ret_cnt,
    output logic [RET_N*TAG_W-1:0] ret_tag,
    output logic                   exc_req,
    output logic [TAG_W-1:0]       exc_tag
);

    logic stop;

    // In-order window scan with a stop at the first blocked slot.
    always_comb begin
        ret_cnt = '0;
        exc_req = 1'b0;
        exc_tag = '0;
        stop    = 1'b0;
        for (int k = 0; k < RET_N; k++) begin
            if (!stop) begin
                if (int'(occ) > k
                    && ent[head_idx + TAG_W'(k)].fin
                    && !ent[head_idx + TAG_W'(k)].exc
                    && (!ent[head_idx + TAG_W'(k)].is_br
                        || ent[head_idx + TAG_W'(k)].br_done)) begin
                    ret_cnt = ret_cnt + RW'(1);
                end else begin
                    stop = 1'b1;
                    if (int'(occ) > k && ent[head_idx + TAG_W'(k)].fin
                        && ent[head_idx + TAG_W'(k)].exc) begin
                        exc_req = 1'b1;
                        exc_tag = head_idx + TAG_W'(k);
                    end
                end
            end
        end
    end

    for (genvar k = 0; k < RET_N; k++) begin : g_rtag
        assign ret_tag[k*TAG_W +: TAG_W] = head_idx + TAG_W'(k);
    end

    // R5
    ret_le_occ_chk: assert property (@(posedge clk) disable iff (!rst_n)
        PTR_W'(ret_cnt) <= occ);

    // R8
    exc_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req |-> int'(ret_cnt) < RET_N);

endmodule

// File: rtl/inorder_cq.sv
// In-order completion queue: claims at the tail, finish/resolve by tag,
// in-order retirement from the head with exception and mispredict flush.
// Assumes: a resolve only names a branch still in the queue; callers honour
// free_cnt, and an over-sized claim is refused outright.
module inorder_cq
    import cq_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int ALLOC_N = 3,
    parameter int RET_N   = 3,
    parameter int FIN_N   = 2,
    localparam int TAG_W  = $clog2(DEPTH),
    localparam int PTR_W  = TAG_W + 1,
    localparam int AW     = $clog2(ALLOC_N + 1),
    localparam int RW     = $clog2(RET_N + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [AW-1:0]            alloc_cnt,
    input  logic [ALLOC_N-1:0]       alloc_br,
    output logic [ALLOC_N*TAG_W-1:0] alloc_tag,
    output logic [PTR_W-1:0]         free_cnt,
    input  logic [FIN_N-1:0]         fin_vld,
    input  logic [FIN_N*TAG_W-1:0]   fin_tag,
    input  logic [FIN_N-1:0]         fin_exc,
    input  logic                     br_vld,
    input  logic [TAG_W-1:0]         br_tag,
    input  logic                     br_mis,
    output logic [RW-1:0]            ret_cnt,
    output logic [RET_N*TAG_W-1:0]   ret_tag,
    output logic                     exc_req,
    output logic [TAG_W-1:0]         exc_tag
);

    logic [TAG_W-1:0]    head_idx, tail_idx, br_off;
    logic [PTR_W-1:0]    occ;
    logic [AW-1:0]       alloc_take;
    logic                br_live, br_flush;
    logic [DEPTH-1:0]    wr_en, wr_br;
    cq_ent_t [DEPTH-1:0] ent;

    // Locate the resolved branch relative to the head.
    always_comb begin
        br_off   = br_tag - head_idx;
        br_live  = br_vld && (PTR_W'(br_off) < occ);
        br_flush = br_live && br_mis && !exc_req;
    end

    // Expand the granted claim into per-slot write enables.
    always_comb begin
        wr_en = '0;
        wr_br = '0;
        for (int k = 0; k < ALLOC_N; k++) begin
            if (k < int'(alloc_take)) begin
                wr_en[tail_idx + TAG_W'(k)] = 1'b1;
                wr_br[tail_idx + TAG_W'(k)] = alloc_br[k];
            end
        end
    end

    for (genvar k = 0; k < ALLOC_N; k++) begin : g_atag
        assign alloc_tag[k*TAG_W +: TAG_W] = tail_idx + TAG_W'(k);
    end

    cq_ptrs #(.DEPTH(DEPTH), .ALLOC_N(ALLOC_N), .RET_N(RET_N)) u_ptrs (
        .clk        (clk),
        .rst_n      (rst_n),
        .ret_cnt    (ret_cnt),
        .alloc_req  (alloc_cnt),
        .flush_all  (exc_req),
        .br_flush   (br_flush),
        .br_off     (br_off),
        .head_idx   (head_idx),
        .tail_idx   (tail_idx),
        .occ        (occ),
        .free_cnt   (free_cnt),
        .alloc_take (alloc_take)
    );

    cq_ent_array #(.DEPTH(DEPTH), .FIN_N(FIN_N)) u_ents (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_br   (wr_br),
        .fin_vld (fin_vld),
        .fin_tag (fin_tag),
        .fin_exc (fin_exc),
        .br_live (br_live),
        .br_tag  (br_tag),
        .ent     (ent)
    );

    cq_retire_sel #(.DEPTH(DEPTH), .RET_N(RET_N)) u_sel (
        .clk      (clk),
        .rst_n    (rst_n),
        .ent      (ent),
        .head_idx (head_idx),
        .occ      (occ),
        .ret_cnt  (ret_cnt),
        .ret_tag  (ret_tag),
        .exc_req  (exc_req),
        .exc_tag  (exc_tag)
    );

    // R7
    br_next_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        br_flush |=> alloc_tag[TAG_W-1:0] == $past(br_tag) + TAG_W'(1));

endmodule

// File: tb/inorder_cq_tb.sv
`timescale 1ns/1ps
module inorder_cq_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  alloc_cnt = '0;
    logic [2:0]  alloc_br = '0;
    logic [11:0] alloc_tag;
    logic [4:0]  free_cnt;
    logic [1:0]  fin_vld = '0;
    logic [7:0]  fin_tag = '0;
    logic [1:0]  fin_exc = '0;
    logic        br_vld = 1'b0;
    logic [3:0]  br_tag = '0;
    logic        br_mis = 1'b0;
    logic [1:0]  ret_cnt;
    logic [11:0] ret_tag;
    logic        exc_req;
    logic [3:0]  exc_tag;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    inorder_cq u_dut (
        .clk(clk), .rst_n(rst_n),
        .alloc_cnt(alloc_cnt), .alloc_br(alloc_br), .alloc_tag(alloc_tag),
        .free_cnt(free_cnt),
        .fin_vld(fin_vld), .fin_tag(fin_tag), .fin_exc(fin_exc),
        .br_vld(br_vld), .br_tag(br_tag), .br_mis(br_mis),
        .ret_cnt(ret_cnt), .ret_tag(ret_tag),
        .exc_req(exc_req), .exc_tag(exc_tag)
    );

    typedef struct packed {
        logic [1:0] acnt;
        logic [2:0] abr;
        logic [1:0] fvld;
        logic [3:0] ft0;
        logic [3:0] ft1;
        logic [1:0] fexc;
        logic       bvld;
        logic [3:0] btag;
        logic       bmis;
        logic [4:0] e_free;
        logic [1:0] e_ret;
        logic       e_exc;
        logic [3:0] e_etag;
        logic [3:0] e_atag;
    } vec_t;

    // acnt abr fvld ft0 ft1 fexc bvld btag bmis | free ret exc etag atag
    localparam vec_t TBL [12] = '{
        '{2'd3, 3'b000, 2'b00, 4'd0, 4'd0, 2'b00, 1'b0, 4'd0, 1'b0, 5'd13, 2'd0, 1'b0, 4'd0, 4'd3},
        '{2'd0, 3'b000, 2'b11, 4'd0, 4'd1, 2'b00, 1'b0, 4'd0, 1'b0, 5'd13, 2'd2, 1'b0, 4'd0, 4'd3},
        '{2'd3, 3'b010, 2'b01, 4'd2, 4'd0, 2'b00, 1'b0, 4'd0, 1'b0, 5'd12, 2'd1, 1'b0, 4'd0, 4'd6},
        '{2'd0, 3'b000, 2'b11, 4'd3, 4'd4, 2'b00, 1'b0, 4'd0, 1'b0, 5'd13, 2'd1, 1'b0, 4'd0, 4'd6},
        '{2'd0, 3'b000, 2'b01, 4'd5, 4'd0, 2'b00, 1'b1, 4'd4, 1'b0, 5'd14, 2'd2, 1'b0, 4'd0, 4'd6},
        '{2'd0, 3'b000, 2'b00, 4'd0, 4'd0, 2'b00, 1'b0, 4'd0, 1'b0, 5'd16, 2'd0, 1'b0, 4'd0, 4'd6},
        '{2'd3, 3'b001, 2'b00, 4'd0, 4'd0, 2'b00, 1'b0, 4'd0, 1'b0, 5'd13, 2'd0, 1'b0, 4'd0, 4'd9},
        '{2'd2, 3'b000, 2'b11, 4'd6, 4'd7, 2'b00, 1'b0, 4'd0, 1'b0, 5'd11, 2'd0, 1'b0, 4'd0, 4'd11},
        '{2'd3, 3'b000, 2'b01, 4'd8, 4'd0, 2'b00, 1'b1, 4'd6, 1'b1, 5'd15, 2'd1, 1'b0, 4'd0, 4'd7},
        '{2'd2, 3'b000, 2'b00, 4'd0, 4'd0, 2'b00, 1'b0, 4'd0, 1'b0, 5'd14, 2'd0, 1'b0, 4'd0, 4'd9},
        '{2'd0, 3'b000, 2'b11, 4'd7, 4'd8, 2'b01, 1'b0, 4'd0, 1'b0, 5'd14, 2'd0, 1'b1, 4'd7, 4'd9},
        '{2'd1, 3'b000, 2'b00, 4'd0, 4'd0, 2'b00, 1'b0, 4'd0, 1'b0, 5'd16, 2'd0, 1'b0, 4'd0, 4'd7}
    };

    // Compare one value and log a failure.
    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    // Drive one cycle of inputs, pass the edge, then idle the inputs.
    task automatic cyc(input logic [1:0] ac, input logic [2:0] ab,
                       input logic [1:0] fv, input logic [3:0] t0,
                       input logic [3:0] t1, input logic [1:0] fe,
                       input logic bv, input logic [3:0] bt, input logic bm);
        alloc_cnt = ac; alloc_br = ab;
        fin_vld = fv; fin_tag = {t1, t0}; fin_exc = fe;
        br_vld = bv; br_tag = bt; br_mis = bm;
        @(posedge clk); #1;
        alloc_cnt = '0; alloc_br = '0; fin_vld = '0; fin_tag = '0;
        fin_exc = '0; br_vld = 1'b0; br_tag = '0; br_mis = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL R1 watchdog act=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int next_tag;
        int sum;
        do_reset();
        // R1 reset state
        check("R1 free", free_cnt, 16);
        check("R1 ret", ret_cnt, 0);
        check("R1 exc", exc_req, 0);
        check("R1 tag0", alloc_tag[3:0], 0);

        // Table walk: R2 R4 R5 R6 R7 R8
        for (int i = 0; i < 12; i++) begin
            cyc(TBL[i].acnt, TBL[i].abr, TBL[i].fvld, TBL[i].ft0, TBL[i].ft1,
                TBL[i].fexc, TBL[i].bvld, TBL[i].btag, TBL[i].bmis);
            check($sformatf("R2 free v%0d", i), free_cnt, TBL[i].e_free);
            check($sformatf("R5 ret v%0d", i), ret_cnt, TBL[i].e_ret);
            check($sformatf("R8 exc v%0d", i), exc_req, TBL[i].e_exc);
            if (TBL[i].e_exc)
                check($sformatf("R8 etag v%0d", i), exc_tag, TBL[i].e_etag);
            check($sformatf("R7 atag v%0d", i), alloc_tag[3:0], TBL[i].e_atag);
        end

        // Fill to full, refusal and wrap: R1 R3 R9
        do_reset();
        for (int n = 0; n < 5; n++) cyc(2'd3, 3'b000, 2'b00, 0, 0, 2'b00, 0, 0, 0);
        check("R2 free after 15", free_cnt, 1);
        check("R2 tag after 15", alloc_tag[3:0], 15);
        check("R2 tag field2", alloc_tag[11:8], 1);
        cyc(2'd3, 3'b000, 2'b00, 0, 0, 2'b00, 0, 0, 0);
        check("R3 refused free", free_cnt, 1);
        check("R3 refused tag", alloc_tag[3:0], 15);
        cyc(2'd1, 3'b000, 2'b00, 0, 0, 2'b00, 0, 0, 0);
        check("R1 full free", free_cnt, 0);
        check("R9 wrap tag", alloc_tag[3:0], 0);

        // Drain all 16 in order: R5 R9
        next_tag = 0;
        sum = 0;
        for (int t = 0; t < 24; t++) begin
            if (t < 8)
                cyc(2'd0, 3'b000, 2'b11, 4'(2*t), 4'(2*t+1), 2'b00, 0, 0, 0);
            else
                cyc(2'd0, 3'b000, 2'b00, 0, 0, 2'b00, 0, 0, 0);
            for (int k = 0; k < int'(ret_cnt); k++) begin
                check("R5 order", ret_tag[k*4 +: 4], next_tag % 16);
                next_tag++;
            end
            sum += int'(ret_cnt);
            if (free_cnt == 5'd16) break;
        end
        check("R9 drained free", free_cnt, 16);
        check("R9 retired count", sum, 16);

        // Three wide, in-order stop, finish-to-retire latency: R4 R5
        cyc(2'd3, 3'b000, 2'b00, 0, 0, 2'b00, 0, 0, 0);
        cyc(2'd0, 3'b000, 2'b11, 4'd1, 4'd2, 2'b00, 0, 0, 0);
        check("R5 head blocks", ret_cnt, 0);
        alloc_cnt = '0;
        fin_vld = 2'b01; fin_tag = 8'h00;
        #0.5;
        check("R4 same cycle", ret_cnt, 0);
        @(posedge clk); #1;
        fin_vld = '0;
        check("R4 next cycle", ret_cnt, 3);
        check("R5 tag0", ret_tag[3:0], 0);
        check("R5 tag2", ret_tag[11:8], 2);
        cyc(2'd0, 3'b000, 2'b00, 0, 0, 2'b00, 0, 0, 0);
        check("R5 empty", free_cnt, 16);

        // Exception behind an older retiring slot, with a competing mispredict: R8
        cyc(2'd3, 3'b000, 2'b00, 0, 0, 2'b00, 0, 0, 0);
        cyc(2'd0, 3'b000, 2'b11, 4'd3, 4'd4, 2'b10, 0, 0, 0);
        check("R8 older retires", ret_cnt, 1);
        check("R8 req", exc_req, 1);
        check("R8 tag", exc_tag, 4);
        cyc(2'd2, 3'b000, 2'b00, 0, 0, 2'b00, 1, 4'd5, 1);
        check("R8 flushed", free_cnt, 16);
        check("R8 req clear", exc_req, 0);
        check("R8 next tag", alloc_tag[3:0], 4);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule